// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block holds the stores of one thread of an out-of-order core, from allocation until memory confirms their writes. Stores take a slot at the tail in program order, carrying a sequence number. Later, each slot receives its address, byte size and up to 16 bytes of data, in any order. A commit port names a youngest sequence number, and every older store becomes committed and eligible to write.

A separate writeback pointer walks the queue. It offers the oldest committed store that has its data to a data-cache request port, one store at a time, under a valid/ready handshake. Writes are confirmed in issue order. A slot is released only when its write is confirmed, not when it commits, so the queue uses three pointers: head (oldest held), writeback (next to send) and tail (next free). The queue is circular and keeps one slot spare, so it reports full one slot early. A store that crosses a cache-line boundary carries a split flag with its request.

A squash port removes uncommitted stores younger than a given sequence number by pulling the tail back. Counts of held stores and of stores waiting to write are exported, along with a full flag and a flag that writes are pending.

Top module: `store_queue_wb`

## Requirements
- R1: After a synchronous active-low reset, the held count and waiting count are 0, full is low and no write request is offered.
- R2: `alloc_ok_o` is high exactly when `alloc_valid_i` is high, the queue is not full and no squash is requested in the same cycle. An accepted store takes the slot shown on `alloc_idx_o`, and slot indices advance by one, wrapping from SLOTS-1 to 0.
- R3: `full_o` is high when the held count is at least SLOTS-1, so one slot always stays spare. An allocation while full is ignored.
- R4: An execute write to a held slot loads its address, size and data and marks it filled. It is ignored for a free slot, and for a slot that is already both committed and filled.
- R5: The split flag of a store is 1 when (address mod LINE_BYTES) + size exceeds LINE_BYTES, with default LINE_BYTES = 16.
- R6: A commit marks every held, uncommitted store whose sequence number is unsigned-less than `commit_seq_i` as committed, and adds that number of stores to the waiting count.
- R7: `wr_valid_o` is high exactly when the oldest held store not yet sent is committed and filled. The request fields show that store's address, size, data and split flag.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, the request is held unchanged. On a handshake the writeback pointer moves to the next store and the waiting count drops by one.
- R9: `wr_done_i` releases the oldest sent store and lowers the held count by one. It is ignored when no sent store is awaiting confirmation.
- R10: A squash removes every uncommitted held store whose sequence number exceeds `squash_seq_i` and moves the tail back to just past the survivors. Committed stores are never removed. In a squash cycle, allocation and commit are ignored.
- R11: `has_wb_o` is high exactly when the waiting count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid_i | input | 1 | Request to allocate a store |
| alloc_seq_i | input | SEQ_W | Sequence number of the new store |
| alloc_ok_o | output | 1 | Allocation accepted this cycle |
| alloc_idx_o | output | IDX_W | Slot the new store takes |
| exec_valid_i | input | 1 | Execute write strobe |
| exec_idx_i | input | IDX_W | Slot written by execute |
| exec_addr_i | input | ADDR_W | Store address |
| exec_size_i | input | SIZE_W | Store size in bytes |
| exec_data_i | input | 8*DATA_BYTES | Store data |
| commit_valid_i | input | 1 | Commit strobe |
| commit_seq_i | input | SEQ_W | Youngest sequence number; older stores commit |
| squash_valid_i | input | 1 | Squash strobe |
| squash_seq_i | input | SEQ_W | Stores younger than this are removed |
| wr_valid_o | output | 1 | Write request offered |
| wr_ready_i | input | 1 | Cache accepts the request |
| wr_addr_o | output | ADDR_W | Request address |
| wr_size_o | output | SIZE_W | Request size |
| wr_data_o | output | 8*DATA_BYTES | Request data |
| wr_split_o | output | 1 | Request crosses a line boundary |
| wr_done_i | input | 1 | Oldest sent write has completed |
| store_cnt_o | output | CNT_W | Number of held stores |
| full_o | output | 1 | Queue full |
| towb_cnt_o | output | CNT_W | Committed stores not yet sent |
| has_wb_o | output | 1 | Waiting count is nonzero |

## Verification
The checker watches, on every cycle, that the held count never passes SLOTS-1 and that no allocation is accepted while full or during a squash. It also checks that an accepted allocation with no completion grows the count by one, that a stalled request stays valid with identical fields, and that a request is offered only while writes are pending. Which stores survive a squash, how many stores a commit marks, that execute writes to locked or free slots leave no trace, and the split flag of a request can only be shown by the bench's scenarios against its queue model.

// File: rtl/sq_pkg.sv
// Shared types for the store queue: the per-slot status flags.
package sq_pkg;

    typedef struct packed {
        logic valid;      // slot holds a store
        logic filled;     // address, size and data are present
        logic committed;  // store has committed
        logic can_wb;     // store may be sent to the cache
        logic completed;  // write confirmed by memory
        logic split;      // access crosses a line boundary
    } sq_flags_t;

    localparam sq_flags_t SQ_FLAGS_NEW = '{valid: 1'b1, filled: 1'b0, committed: 1'b0,
                                           can_wb: 1'b0, completed: 1'b0, split: 1'b0};

endpackage

// File: rtl/sq_ptr_ctrl.sv
// Pointer and counter control of the store queue.
// Keeps head (oldest held), writeback (next to send) and tail (next free)
// pointers, the held count and the count of committed stores not yet sent.
// Assumes completions arrive in issue order and SLOTS >= 2.
module sq_ptr_ctrl #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_ok,
    input  logic             issue_fire,
    input  logic             wr_done,
    input  logic             squash_do,
    input  logic [CNT_W-1:0] kept_cnt,
    input  logic [CNT_W-1:0] commit_cnt,
    output logic [IDX_W-1:0] head_ptr,
    output logic [IDX_W-1:0] wb_ptr,
    output logic [IDX_W-1:0] tail_ptr,
    output logic [CNT_W-1:0] store_cnt,
    output logic [CNT_W-1:0] towb_cnt,
    output logic             full,
    output logic             ack_ok
);

    localparam logic [CNT_W:0] SLOTS_W = (CNT_W + 1)'(SLOTS);

    // Advance a slot index by one with wrap-around.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(SLOTS - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    // Add a count to a slot index with wrap-around.
    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
        logic [CNT_W:0] s;
        s = (CNT_W + 1)'(p) + (CNT_W + 1)'(n);
        if (s >= SLOTS_W) s = s - SLOTS_W;
        return IDX_W'(s);
    endfunction

    // A completion is honoured only while a sent store is outstanding.
    assign ack_ok = wr_done && (wb_ptr != head_ptr);

    // One slot stays spare, so full is reported one slot early.
    assign full = (store_cnt >= CNT_W'(SLOTS - 1));

    // Head moves on a completion, writeback pointer on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            wb_ptr   <= '0;
        end else begin
            if (ack_ok)     head_ptr <= bump(head_ptr);
            if (issue_fire) wb_ptr   <= bump(wb_ptr);
        end
    end

    // Tail and held count follow allocation, squash and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_ptr  <= '0;
            store_cnt <= '0;
        end else if (squash_do) begin
            tail_ptr  <= wrap_add(head_ptr, kept_cnt);
            store_cnt <= kept_cnt - CNT_W'(ack_ok);
        end else begin
            if (alloc_ok) tail_ptr <= bump(tail_ptr);
            store_cnt <= store_cnt + CNT_W'(alloc_ok) - CNT_W'(ack_ok);
        end
    end

    // Waiting count rises on commit and falls on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) towb_cnt <= '0;
        else        towb_cnt <= towb_cnt + commit_cnt - CNT_W'(issue_fire);
    end

endmodule

// File: rtl/sq_entry_bank.sv
// Slot storage of the store queue.
// Each slot keeps a sequence number, address, size, data and status flags.
// Decodes allocation, execute, commit, squash and release per slot and
// reports how many slots commit and how many survive a squash.
// Assumes held sequence numbers rise in program order.
module sq_entry_bank import sq_pkg::*; #(
    parameter int SLOTS      = 8,
    parameter int SEQ_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int SIZE_W = $clog2(DATA_BYTES + 1),
    localparam int DATA_W = 8 * DATA_BYTES,
    localparam int OFF_W  = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [SIZE_W-1:0] exec_size,
    input  logic [DATA_W-1:0] exec_data,
    input  logic              commit_do,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_do,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              free_we,
    input  logic [IDX_W-1:0]  free_idx,
    output sq_flags_t         flags_o [SLOTS],
    output logic [ADDR_W-1:0] addr_o  [SLOTS],
    output logic [SIZE_W-1:0] size_o  [SLOTS],
    output logic [DATA_W-1:0] data_o  [SLOTS],
    output logic [CNT_W-1:0]  commit_cnt_o,
    output logic [CNT_W-1:0]  kept_cnt_o
);

    logic             exec_split;
    logic [SLOTS-1:0] valid_v;
    logic [SLOTS-1:0] drop_v;
    logic [SLOTS-1:0] commit_v;

    // Line-crossing test for the incoming execute write.
    always_comb exec_split = (int'(exec_addr[OFF_W-1:0]) + int'(exec_size)) > LINE_BYTES;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        sq_flags_t         fl_q;
        logic [SEQ_W-1:0]  seq_q;
        logic [ADDR_W-1:0] addr_q;
        logic [SIZE_W-1:0] size_q;
        logic [DATA_W-1:0] data_q;
        logic              hit_alloc;
        logic              hit_exec;
        logic              hit_free;

        assign hit_alloc   = alloc_we && (alloc_idx == IDX_W'(i));
        assign hit_exec    = exec_valid && (exec_idx == IDX_W'(i)) && fl_q.valid
                             && !(fl_q.committed && fl_q.filled);
        assign hit_free    = free_we && (free_idx == IDX_W'(i));
        assign commit_v[i] = commit_do && fl_q.valid && !fl_q.committed && (seq_q < commit_seq);
        assign drop_v[i]   = squash_do && fl_q.valid && !fl_q.committed && (seq_q > squash_seq);
        assign valid_v[i]  = fl_q.valid;

        // Slot state update: allocate, drop on squash, or apply release/execute/commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fl_q   <= '0;
                seq_q  <= '0;
                addr_q <= '0;
                size_q <= '0;
                data_q <= '0;
            end else if (hit_alloc) begin
                fl_q  <= SQ_FLAGS_NEW;
                seq_q <= alloc_seq;
            end else if (drop_v[i]) begin
                fl_q.valid <= 1'b0;
            end else begin
                if (hit_free) begin
                    fl_q.valid     <= 1'b0;
                    fl_q.completed <= 1'b1;
                end
                if (hit_exec) begin
                    addr_q      <= exec_addr;
                    size_q      <= exec_size;
                    data_q      <= exec_data;
                    fl_q.filled <= 1'b1;
                    fl_q.split  <= exec_split;
                end
                if (commit_v[i]) begin
                    fl_q.committed <= 1'b1;
                    fl_q.can_wb    <= 1'b1;
                end
            end
        end

        assign flags_o[i] = fl_q;
        assign addr_o[i]  = addr_q;
        assign size_o[i]  = size_q;
        assign data_o[i]  = data_q;
    end

    assign commit_cnt_o = CNT_W'($countones(commit_v));
    assign kept_cnt_o   = CNT_W'($countones(valid_v & ~drop_v));

endmodule

// File: rtl/sq_wb_sel.sv
// Write request selection of the store queue.
// Presents the slot under the writeback pointer to the cache port and
// raises valid only when that store is committed, filled and unconfirmed.
module sq_wb_sel import sq_pkg::*; #(
    parameter int SLOTS      = 8,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int SIZE_W = $clog2(DATA_BYTES + 1),
    localparam int DATA_W = 8 * DATA_BYTES
) (
    input  logic [IDX_W-1:0]  wb_ptr,
    input  sq_flags_t         flags_i [SLOTS],
    input  logic [ADDR_W-1:0] addr_i  [SLOTS],
    input  logic [SIZE_W-1:0] size_i  [SLOTS],
    input  logic [DATA_W-1:0] data_i  [SLOTS],
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SIZE_W-1:0] wr_size,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_split
);

    sq_flags_t cur;

    // Read the slot under the writeback pointer and decide eligibility.
    always_comb begin
        cur      = flags_i[wb_ptr];
        wr_valid = cur.valid && cur.committed && cur.can_wb && cur.filled && !cur.completed;
        wr_addr  = addr_i[wb_ptr];
        wr_size  = size_i[wb_ptr];
        wr_data  = data_i[wb_ptr];
        wr_split = cur.split;
    end

endmodule

// File: rtl/store_queue_wb.sv
// Store queue with writeback pointer, top level.
// Allocates stores in program order, collects their execute data, marks them
// committed, sends them to the cache one at a time and releases each slot on
// its write confirmation. A squash pulls the tail back over uncommitted stores.
// Assumes in-order write confirmations and rising sequence numbers.
module store_queue_wb import sq_pkg::*; #(
    parameter int SLOTS      = 8,
    parameter int SEQ_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int SIZE_W = $clog2(DATA_BYTES + 1),
    localparam int DATA_W = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [SEQ_W-1:0]  alloc_seq_i,
    output logic              alloc_ok_o,
    output logic [IDX_W-1:0]  alloc_idx_o,
    input  logic              exec_valid_i,
    input  logic [IDX_W-1:0]  exec_idx_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic [SIZE_W-1:0] exec_size_i,
    input  logic [DATA_W-1:0] exec_data_i,
    input  logic              commit_valid_i,
    input  logic [SEQ_W-1:0]  commit_seq_i,
    input  logic              squash_valid_i,
    input  logic [SEQ_W-1:0]  squash_seq_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [SIZE_W-1:0] wr_size_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_split_o,
    input  logic              wr_done_i,
    output logic [CNT_W-1:0]  store_cnt_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  towb_cnt_o,
    output logic              has_wb_o
);

    logic [IDX_W-1:0]  head_ptr;
    logic [IDX_W-1:0]  wb_ptr;
    logic [IDX_W-1:0]  tail_ptr;
    logic [CNT_W-1:0]  kept_cnt;
    logic [CNT_W-1:0]  commit_cnt;
    logic              ack_ok;
    logic              issue_fire;
    logic              commit_do;
    sq_flags_t         slot_flags [SLOTS];
    logic [ADDR_W-1:0] slot_addr  [SLOTS];
    logic [SIZE_W-1:0] slot_size  [SLOTS];
    logic [DATA_W-1:0] slot_data  [SLOTS];

    // Squash wins over allocation and commit in the same cycle.
    assign alloc_ok_o  = alloc_valid_i && !full_o && !squash_valid_i;
    assign commit_do   = commit_valid_i && !squash_valid_i;
    assign issue_fire  = wr_valid_o && wr_ready_i;
    assign alloc_idx_o = tail_ptr;
    assign has_wb_o    = (towb_cnt_o != '0);

    sq_ptr_ctrl #(.SLOTS(SLOTS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_ok   (alloc_ok_o),
        .issue_fire (issue_fire),
        .wr_done    (wr_done_i),
        .squash_do  (squash_valid_i),
        .kept_cnt   (kept_cnt),
        .commit_cnt (commit_cnt),
        .head_ptr   (head_ptr),
        .wb_ptr     (wb_ptr),
        .tail_ptr   (tail_ptr),
        .store_cnt  (store_cnt_o),
        .towb_cnt   (towb_cnt_o),
        .full       (full_o),
        .ack_ok     (ack_ok)
    );

    sq_entry_bank #(
        .SLOTS(SLOTS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
        .DATA_BYTES(DATA_BYTES), .LINE_BYTES(LINE_BYTES)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_we     (alloc_ok_o),
        .alloc_idx    (tail_ptr),
        .alloc_seq    (alloc_seq_i),
        .exec_valid   (exec_valid_i),
        .exec_idx     (exec_idx_i),
        .exec_addr    (exec_addr_i),
        .exec_size    (exec_size_i),
        .exec_data    (exec_data_i),
        .commit_do    (commit_do),
        .commit_seq   (commit_seq_i),
        .squash_do    (squash_valid_i),
        .squash_seq   (squash_seq_i),
        .free_we      (ack_ok),
        .free_idx     (head_ptr),
        .flags_o      (slot_flags),
        .addr_o       (slot_addr),
        .size_o       (slot_size),
        .data_o       (slot_data),
        .commit_cnt_o (commit_cnt),
        .kept_cnt_o   (kept_cnt)
    );

    sq_wb_sel #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_sel (
        .wb_ptr   (wb_ptr),
        .flags_i  (slot_flags),
        .addr_i   (slot_addr),
        .size_i   (slot_size),
        .data_i   (slot_data),
        .wr_valid (wr_valid_o),
        .wr_addr  (wr_addr_o),
        .wr_size  (wr_size_o),
        .wr_data  (wr_data_o),
        .wr_split (wr_split_o)
    );

endmodule

// File: rtl/sq_chk.sv
// Property checker for the store queue, attached to the top by bind.
module sq_chk #(
    parameter int SLOTS      = 8,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int SIZE_W = $clog2(DATA_BYTES + 1),
    localparam int DATA_W = 8 * DATA_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_ok_o,
    input logic              squash_valid_i,
    input logic              full_o,
    input logic [CNT_W-1:0]  store_cnt_o,
    input logic              has_wb_o,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [SIZE_W-1:0] wr_size_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              wr_done_i
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_cnt_o <= CNT_W'(SLOTS - 1));

    // R3
    no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !alloc_ok_o);

    // R2
    alloc_grows_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok_o && !wr_done_i |=> store_cnt_o == $past(store_cnt_o) + CNT_W'(1));

    // R10
    squash_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid_i |-> !alloc_ok_o);

    // R8
    stall_holds_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                      && $stable(wr_size_o) && $stable(wr_data_o));

    // R11
    request_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> has_wb_o);

endmodule

bind store_queue_wb sq_chk #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_ok_o     (alloc_ok_o),
    .squash_valid_i (squash_valid_i),
    .full_o         (full_o),
    .store_cnt_o    (store_cnt_o),
    .has_wb_o       (has_wb_o),
    .wr_valid_o     (wr_valid_o),
    .wr_ready_i     (wr_ready_i),
    .wr_addr_o      (wr_addr_o),
    .wr_size_o      (wr_size_o),
    .wr_data_o      (wr_data_o),
    .wr_done_i      (wr_done_i)
);

// File: tb/sim_store_queue_wb.sv
// Bench for store_queue_wb: directed corner cases, then seeded random traffic,
// all compared against a queue model built from the requirements.
module sim_store_queue_wb;

    localparam int CLK_PERIOD = 10;
    localparam int S = 8;
    localparam int LINE = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         alloc_valid;
    logic [15:0]  alloc_seq;
    logic         alloc_ok;
    logic [2:0]   alloc_idx;
    logic         exec_valid;
    logic [2:0]   exec_idx;
    logic [31:0]  exec_addr;
    logic [4:0]   exec_size;
    logic [127:0] exec_data;
    logic         commit_valid;
    logic [15:0]  commit_seq;
    logic         squash_valid;
    logic [15:0]  squash_seq;
    logic         wr_valid;
    logic         wr_ready;
    logic [31:0]  wr_addr;
    logic [4:0]   wr_size;
    logic [127:0] wr_data;
    logic         wr_split;
    logic         wr_done;
    logic [3:0]   store_cnt;
    logic         full;
    logic [3:0]   towb_cnt;
    logic         has_wb;

    always #(CLK_PERIOD / 2) clk = ~clk;

    store_queue_wb u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_seq_i(alloc_seq),
        .alloc_ok_o(alloc_ok), .alloc_idx_o(alloc_idx),
        .exec_valid_i(exec_valid), .exec_idx_i(exec_idx), .exec_addr_i(exec_addr),
        .exec_size_i(exec_size), .exec_data_i(exec_data),
        .commit_valid_i(commit_valid), .commit_seq_i(commit_seq),
        .squash_valid_i(squash_valid), .squash_seq_i(squash_seq),
        .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
        .wr_size_o(wr_size), .wr_data_o(wr_data), .wr_split_o(wr_split),
        .wr_done_i(wr_done),
        .store_cnt_o(store_cnt), .full_o(full), .towb_cnt_o(towb_cnt), .has_wb_o(has_wb)
    );

    typedef struct {
        logic [15:0]  seq;
        logic [31:0]  addr;
        logic [4:0]   size;
        logic [127:0] data;
        bit           filled;
        bit           comm;
        bit           iss;
        int           idx;
    } ment_t;

    ment_t       mq[$];
    int          m_head, m_tail, m_towb;
    int          n_cmp, n_bad;
    logic [15:0] next_seq;
    bit          finished;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_split(logic [31:0] a, logic [4:0] sz);
        return (int'(a % LINE) + int'(sz)) > LINE;
    endfunction

    task automatic check_state();
        chk("R9/R10 store count", 128'(store_cnt), 128'(mq.size()));
        chk("R3 full", 128'(full), 128'(mq.size() >= S - 1));
        chk("R6/R8 waiting count", 128'(towb_cnt), 128'(m_towb));
        chk("R11 has_wb", 128'(has_wb), 128'(m_towb != 0));
    endtask

    task automatic clear_in();
        alloc_valid = 0; alloc_seq = next_seq;
        exec_valid = 0; exec_idx = 0; exec_addr = 0; exec_size = 0; exec_data = 0;
        commit_valid = 0; commit_seq = 0; squash_valid = 0; squash_seq = 0;
        wr_ready = 1; wr_done = 0;
    endtask

    // Inputs are set at a falling edge; check, step the model, wait one cycle.
    task automatic run_cycle();
        int  fu;
        int  outst;
        bit  ev;
        bit  exp_ok;
        bit  fire;
        #1;
        exp_ok = alloc_valid && (mq.size() < S - 1) && !squash_valid;
        chk("R2 alloc_ok", 128'(alloc_ok), 128'(exp_ok));
        if (alloc_valid) chk("R2 alloc_idx", 128'(alloc_idx), 128'(m_tail));
        fu = -1;
        outst = 0;
        foreach (mq[k]) begin
            if (mq[k].iss) outst++;
            else if (fu < 0) fu = k;
        end
        ev = (fu >= 0) && mq[fu].comm && mq[fu].filled;
        chk("R7 wr_valid", 128'(wr_valid), 128'(ev));
        if (ev) begin
            chk("R7 wr_addr", 128'(wr_addr), 128'(mq[fu].addr));
            chk("R4 wr_size", 128'(wr_size), 128'(mq[fu].size));
            chk("R4 wr_data", wr_data, mq[fu].data);
            chk("R5 wr_split", 128'(wr_split), 128'(exp_split(mq[fu].addr, mq[fu].size)));
        end
        fire = ev && wr_ready;
        // execute write
        if (exec_valid) begin
            foreach (mq[k]) begin
                if (mq[k].idx == int'(exec_idx) && !(mq[k].comm && mq[k].filled)) begin
                    mq[k].addr = exec_addr; mq[k].size = exec_size;
                    mq[k].data = exec_data; mq[k].filled = 1;
                end
            end
        end
        // commit
        if (commit_valid && !squash_valid) begin
            foreach (mq[k]) begin
                if (!mq[k].comm && mq[k].seq < commit_seq) begin
                    mq[k].comm = 1; m_towb++;
                end
            end
        end
        // handshake
        if (fire) begin
            mq[fu].iss = 1; m_towb--;
        end
        // squash
        if (squash_valid) begin
            while (mq.size() > 0 && !mq[mq.size() - 1].comm && mq[mq.size() - 1].seq > squash_seq)
                void'(mq.pop_back());
            m_tail = (m_head + mq.size()) % S;
        end
        // completion
        if (wr_done && outst > 0) begin
            void'(mq.pop_front());
            m_head = (m_head + 1) % S;
        end
        // allocation
        if (exp_ok) begin
            ment_t e;
            e.seq = alloc_seq; e.addr = 0; e.size = 0; e.data = 0;
            e.filled = 0; e.comm = 0; e.iss = 0; e.idx = m_tail;
            mq.push_back(e);
            m_tail = (m_tail + 1) % S;
            next_seq = next_seq + 16'(1 + $urandom % 3);
        end
        @(negedge clk);
        check_state();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        n_cmp = 0; n_bad = 0; finished = 0;
        m_head = 0; m_tail = 0; m_towb = 0; next_seq = 16'd1;
        rst_n = 0;
        clear_in();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 store count", 128'(store_cnt), 0);
        chk("R1 full", 128'(full), 0);
        chk("R1 waiting count", 128'(towb_cnt), 0);
        chk("R1 wr_valid", 128'(wr_valid), 0);
        rst_n = 1;

        // R3: fill with completions idle; the eighth request is refused
        for (int k = 0; k < S; k++) begin
            clear_in(); alloc_valid = 1; run_cycle();
        end
        clear_in();
        // R4/R5: load all held stores, slot 2 crosses a line boundary
        for (int k = 0; k < mq.size(); k++) begin
            clear_in();
            exec_valid = 1; exec_idx = 3'(mq[k].idx);
            exec_addr = (k == 2) ? 32'h100C : 32'h2000 + 32'(k * 16);
            exec_size = (k == 2) ? 5'd8 : 5'd4;
            exec_data = {4{32'hA500_0000 + 32'(k)}};
            run_cycle();
        end
        // R6/R8: commit three stores while the cache stalls
        clear_in(); wr_ready = 0; commit_valid = 1; commit_seq = mq[3].seq; run_cycle();
        clear_in(); wr_ready = 0;
        repeat (3) run_cycle();
        // R4: execute to a committed, filled slot is ignored
        exec_valid = 1; exec_idx = 3'(mq[0].idx); exec_addr = 32'hDEAD_0000;
        exec_size = 5'd1; exec_data = '1; run_cycle();
        // R10: squash younger uncommitted stores; allocation in the same cycle refused
        clear_in(); wr_ready = 0; squash_valid = 1; squash_seq = mq[4].seq;
        alloc_valid = 1; commit_valid = 1; commit_seq = 16'hFFFF; run_cycle();
        // R9: completion with nothing outstanding is ignored
        clear_in(); wr_ready = 0; wr_done = 1; run_cycle();
        clear_in();
        repeat (4) run_cycle();
        wr_done = 1;
        repeat (4) run_cycle();

        // Random traffic in phases: mixed, fill-heavy, cache-stall-heavy
        for (int i = 0; i < 4000; i++) begin
            int ph;
            int p_alloc;
            int p_done;
            int p_ready;
            ph = (i / 500) % 4;
            p_alloc = (ph == 1) ? 90 : 50;
            p_done  = (ph == 1) ? 10 : 45;
            p_ready = (ph == 2) ? 25 : 80;
            clear_in();
            alloc_valid = ($urandom % 100) < p_alloc;
            alloc_seq = next_seq;
            exec_valid = ($urandom % 100) < 50;
            exec_idx = 3'($urandom % S);
            if (mq.size() > 0 && ($urandom % 100) < 70)
                exec_idx = 3'(mq[$urandom % mq.size()].idx);
            exec_addr = $urandom;
            exec_size = 5'($urandom_range(1, 16));
            exec_data = {$urandom, $urandom, $urandom, $urandom};
            commit_valid = ($urandom % 100) < 20;
            commit_seq = (mq.size() > 0) ? mq[$urandom % mq.size()].seq + 16'($urandom % 2) : 16'($urandom);
            squash_valid = ($urandom % 100) < 4;
            squash_seq = (mq.size() > 0) ? mq[$urandom % mq.size()].seq : next_seq;
            wr_ready = ($urandom % 100) < p_ready;
            wr_done = ($urandom % 100) < p_done;
            run_cycle();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule